// File: doc/BRIEF.md
# Bidirectional Funnel-Shift Align Unit

This block is a single-cycle datapath slice for a 64-bit integer pipeline. It places two source operands side by side, with the `rt` operand above the `rs` operand, and extracts one word-sized window from the pair. Three operations share the hardware. Two of them are byte-counted alignments: one on a 32-bit word and one on the full 64-bit word. The third is a bit-granular extract on a 32-bit word whose count runs in the opposite direction.

Every operation is first reduced to an internal bit count `n` and a word size of 32 or 64. One funnel core per word size then produces `(rt << n) | (rs >> (W - n))`, truncated to the word size. A count of zero returns `rt`, and a count equal to the word size returns `rs`. Results of the 32-bit operations are sign-extended to 64 bits. The result, a write enable and the destination index are registered once and presented with a valid flag on the following cycle. Instruction fetch, opcode decoding and register-file storage sit outside the block.

Top module: `funnel_align_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (word align), `n` = 8 × `pos_field[1:0]` and W = 32. The result is `rt[31:0] << n | rs[31:0] >> (32 - n)` taken to 32 bits and then sign-extended. A `pos_field[1:0]` of 0 gives the sign-extended `rt[31:0]`.
- R2: With `op_sel` = 2'b01 (doubleword align), `n` = 8 × `pos_field[2:0]` and W = 64. The result is `rt << n | rs >> (64 - n)` taken to 64 bits and is not sign-extended.
- R3: With `op_sel` = 2'b10 (bit extract), `n` = 32 − `pos_field[4:0]` and W = 32, using the same window as R1. A shift field of 0 gives `n` = 32, so the result is the sign-extended `rs[31:0]`.
- R4: Endpoints: when `n` = 0 the result is `rt` taken to the word size, and when `n` = W the result is `rs` taken to the word size.
- R5: For 32-bit operations, bits 63:32 of the result all equal bit 31, and bits 63:32 of `rs` and `rt` have no effect on the result.
- R6: A destination index of 0 gives `wr_en` = 0 while `valid_out` stays 1.
- R7: `op_sel` = 2'b11 is reserved and gives `wr_en` = 0.
- R8: `valid_out` equals `valid_in` delayed by one clock. `wr_idx` is `dst_idx` from that same cycle. `wr_en` is 1 only when `valid_out` is 1.
- R9: While `rst_n` is low and after its release, and until the first valid input, `valid_out`, `wr_en`, `wr_idx` and `result` are all 0.
- R10: Field bits that an operation does not use are ignored: `pos_field[4:2]` for word align and `pos_field[4:3]` for doubleword align.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operation present this cycle |
| op_sel | input | 2 | 00 word align, 01 doubleword align, 10 bit extract, 11 reserved |
| rs_val | input | 64 | Lower half of the funnel pair |
| rt_val | input | 64 | Upper half of the funnel pair |
| pos_field | input | 5 | Raw byte position or bit shift field |
| dst_idx | input | 5 | Destination register index |
| valid_out | output | 1 | Registered result valid |
| wr_en | output | 1 | Register-file write enable |
| wr_idx | output | 5 | Registered destination index |
| result | output | 64 | Registered, sign-extended window |

## Verification
The hardest cases to reach are the two funnel endpoints combined with bit 31 of the selected operand being set. Only these cases show whether the bypass and the sign extension pick the correct source: `rt` for a zero count and `rs` for a full-word count. Uniform random stimulus hits a bit-extract shift of 0 only about once in 32 operations. The bench therefore drives directed operations at every byte position, at the extract shifts 0, 1 and 31, and with 0xFFFF_FFFF placed in the upper halves of the operands. It then runs seeded random operations with idle bubbles, reserved codes and zero destinations mixed in.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

   localparam int unsigned XLEN    = 64;
   localparam int unsigned HALFLEN = 32;
   localparam int unsigned POS_W   = 5;
   localparam int unsigned IDX_W   = 5;
   localparam int unsigned BITS_W  = $clog2(XLEN) + 1;

   typedef enum logic [1:0] {
      OP_WALIGN = 2'b00,
      OP_DALIGN = 2'b01,
      OP_BITEXT = 2'b10,
      OP_RSVD   = 2'b11
   } fsa_op_e;

endpackage

// File: rtl/fsa_count_decode.sv
module fsa_count_decode #(
   parameter int unsigned XW     = 64,
   parameter int unsigned HW     = 32,
   parameter int unsigned PW     = 5,
   parameter int unsigned CW     = $clog2(XW) + 1
) (
   input  logic [1:0]    op_sel,
   input  logic [PW-1:0] pos_field,
   output logic [CW-1:0] bit_cnt,
   output logic          word_wide,
   output logic          op_legal
);
   import fsa_pkg::*;

   localparam int unsigned BSEL_H = $clog2(HW / 8);
   localparam int unsigned BSEL_X = $clog2(XW / 8);

   if (XW != 2 * HW) begin : g_bad_ratio
      $error("fsa_count_decode: XW must be twice HW");
   end
   if (PW < BSEL_X || PW != $clog2(HW)) begin : g_bad_field
      $error("fsa_count_decode: field width does not fit the word sizes");
   end

   fsa_op_e op;
   assign op = fsa_op_e'(op_sel);

   logic [CW-1:0] byte_h_cnt;
   logic [CW-1:0] byte_x_cnt;
   logic [CW-1:0] ext_cnt;

   assign byte_h_cnt = CW'(pos_field[BSEL_H-1:0]) << 3;
   assign byte_x_cnt = CW'(pos_field[BSEL_X-1:0]) << 3;
   assign ext_cnt    = CW'(HW) - CW'(pos_field);

   always_comb begin
      bit_cnt   = '0;
      word_wide = 1'b0;
      op_legal  = 1'b1;
      case (op)
         OP_WALIGN: bit_cnt = byte_h_cnt;
         OP_DALIGN: begin
            bit_cnt   = byte_x_cnt;
            word_wide = 1'b1;
         end
         OP_BITEXT: bit_cnt = ext_cnt;
         default:   op_legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/fsa_funnel_core.sv
module fsa_funnel_core #(
   parameter int unsigned W           = 32,
   parameter bit          BYPASS_ENDS = 1'b1,
   parameter int unsigned CW          = $clog2(W) + 1
) (
   input  logic [W-1:0]  hi_word,
   input  logic [W-1:0]  lo_word,
   input  logic [CW-1:0] bit_cnt,
   output logic [W-1:0]  window
);
   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("fsa_funnel_core: W must be a power of two of at least 8");
   end

   logic [CW-1:0] rdist;
   logic [W-1:0]  hi_part;
   logic [W-1:0]  lo_part;

   assign rdist   = CW'(W) - bit_cnt;
   assign hi_part = hi_word << bit_cnt;
   assign lo_part = lo_word >> rdist;

   if (BYPASS_ENDS) begin : g_bypass
      logic at_zero;
      logic at_full;
      assign at_zero = (bit_cnt == '0);
      assign at_full = (bit_cnt == CW'(W));
      always_comb begin
         if (at_zero)      window = hi_word;
         else if (at_full) window = lo_word;
         else              window = hi_part | lo_part;
      end
   end else begin : g_plain
      assign window = hi_part | lo_part;
   end

endmodule

// File: rtl/fsa_result_stage.sv
module fsa_result_stage #(
   parameter int unsigned XW = 64,
   parameter int unsigned HW = 32,
   parameter int unsigned IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_in,
   input  logic          word_wide,
   input  logic          write_ok,
   input  logic [IW-1:0] dst_idx,
   input  logic [HW-1:0] narrow_win,
   input  logic [XW-1:0] wide_win,
   output logic          valid_out,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [XW-1:0] result
);
   logic [XW-1:0] ext_win;
   logic          zero_dst;

   assign ext_win  = word_wide ? wide_win
                               : {{(XW-HW){narrow_win[HW-1]}}, narrow_win};
   assign zero_dst = (dst_idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         result    <= '0;
      end else begin
         valid_out <= valid_in;
         wr_en     <= valid_in & write_ok & ~zero_dst;
         if (valid_in) begin
            wr_idx <= dst_idx;
            result <= ext_win;
         end
      end
   end

endmodule

// File: rtl/funnel_align_unit.sv
module funnel_align_unit #(
   parameter int unsigned XW          = fsa_pkg::XLEN,
   parameter int unsigned HW          = fsa_pkg::HALFLEN,
   parameter int unsigned PW          = fsa_pkg::POS_W,
   parameter int unsigned IW          = fsa_pkg::IDX_W,
   parameter bit          BYPASS_ENDS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_in,
   input  logic [1:0]    op_sel,
   input  logic [XW-1:0] rs_val,
   input  logic [XW-1:0] rt_val,
   input  logic [PW-1:0] pos_field,
   input  logic [IW-1:0] dst_idx,
   output logic          valid_out,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [XW-1:0] result
);
   localparam int unsigned CWX = $clog2(XW) + 1;
   localparam int unsigned CWH = $clog2(HW) + 1;

   if (IW < 1) begin : g_bad_idx
      $error("funnel_align_unit: index width must be positive");
   end

   logic [CWX-1:0] bit_cnt;
   logic           word_wide;
   logic           op_legal;
   logic [HW-1:0]  narrow_win;
   logic [XW-1:0]  wide_win;

   fsa_count_decode #(.XW(XW), .HW(HW), .PW(PW), .CW(CWX)) u_dec (
      .op_sel    (op_sel),
      .pos_field (pos_field),
      .bit_cnt   (bit_cnt),
      .word_wide (word_wide),
      .op_legal  (op_legal)
   );

   fsa_funnel_core #(.W(HW), .BYPASS_ENDS(BYPASS_ENDS), .CW(CWH)) u_core_h (
      .hi_word (rt_val[HW-1:0]),
      .lo_word (rs_val[HW-1:0]),
      .bit_cnt (bit_cnt[CWH-1:0]),
      .window  (narrow_win)
   );

   fsa_funnel_core #(.W(XW), .BYPASS_ENDS(BYPASS_ENDS), .CW(CWX)) u_core_x (
      .hi_word (rt_val),
      .lo_word (rs_val),
      .bit_cnt (bit_cnt),
      .window  (wide_win)
   );

   fsa_result_stage #(.XW(XW), .HW(HW), .IW(IW)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_in   (valid_in),
      .word_wide  (word_wide),
      .write_ok   (op_legal),
      .dst_idx    (dst_idx),
      .narrow_win (narrow_win),
      .wide_win   (wide_win),
      .valid_out  (valid_out),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .result     (result)
   );

endmodule

// File: rtl/fsa_checker.sv
module fsa_checker #(
   parameter int unsigned XW = 64,
   parameter int unsigned HW = 32,
   parameter int unsigned PW = 5,
   parameter int unsigned IW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          valid_in,
   input logic [1:0]    op_sel,
   input logic [XW-1:0] rs_val,
   input logic [XW-1:0] rt_val,
   input logic [PW-1:0] pos_field,
   input logic [IW-1:0] dst_idx,
   input logic          valid_out,
   input logic          wr_en,
   input logic [IW-1:0] wr_idx,
   input logic [XW-1:0] result
);

   assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);

   assert_wren_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> valid_out);

   assert_idx_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> (wr_idx == $past(dst_idx)));

   assert_zero_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && dst_idx == '0) |=> !wr_en);

   assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_sel == 2'b11) |=> !wr_en);

   assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && (op_sel == 2'b00 || op_sel == 2'b10))
      |=> (result[XW-1:HW] == {(XW-HW){result[HW-1]}}));

   assert_align_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_sel == 2'b00 && pos_field[1:0] == 2'b00)
      |=> (result == {{(XW-HW){$past(rt_val[HW-1])}}, $past(rt_val[HW-1:0])}));

   assert_extract_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_sel == 2'b10 && pos_field == '0)
      |=> (result == {{(XW-HW){$past(rs_val[HW-1])}}, $past(rs_val[HW-1:0])}));

   assert_dalign_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_sel == 2'b01 && pos_field[2:0] == 3'b000)
      |=> (result == $past(rt_val)));

endmodule

bind funnel_align_unit fsa_checker #(.XW(XW), .HW(HW), .PW(PW), .IW(IW)) u_fsa_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .op_sel    (op_sel),
   .rs_val    (rs_val),
   .rt_val    (rt_val),
   .pos_field (pos_field),
   .dst_idx   (dst_idx),
   .valid_out (valid_out),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .result    (result)
);

// File: tb/funnel_align_unit_test.sv
`timescale 1ns/1ps
module funnel_align_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [63:0] rs_val = '0;
   logic [63:0] rt_val = '0;
   logic [4:0]  pos_field = '0;
   logic [4:0]  dst_idx = '0;
   logic        valid_out;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [63:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   funnel_align_unit uut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel),
      .rs_val(rs_val), .rt_val(rt_val), .pos_field(pos_field), .dst_idx(dst_idx),
      .valid_out(valid_out), .wr_en(wr_en), .wr_idx(wr_idx), .result(result)
   );

   // Bit-by-bit model of the window, written from the requirements.
   function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a_rs,
                                         input logic [63:0] b_rt, input logic [4:0] pos);
      int w;
      int n;
      logic [63:0] r;
      r = '0;
      case (op)
         2'b00:   begin w = 32; n = 8 * int'(pos[1:0]); end
         2'b01:   begin w = 64; n = 8 * int'(pos[2:0]); end
         2'b10:   begin w = 32; n = 32 - int'(pos); end
         default: begin w = 32; n = 0; end
      endcase
      for (int i = 0; i < w; i++)
         r[i] = (i >= n) ? b_rt[i - n] : a_rs[w - n + i];
      if (w == 32) r[63:32] = {32{r[31]}};
      return r;
   endfunction

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a falling edge; drives, waits one clock, checks at the next falling edge.
   task automatic run_op(input logic v, input logic [1:0] op, input logic [63:0] a_rs,
                         input logic [63:0] b_rt, input logic [4:0] pos,
                         input logic [4:0] dst, input string req);
      valid_in  = v;
      op_sel    = op;
      rs_val    = a_rs;
      rt_val    = b_rt;
      pos_field = pos;
      dst_idx   = dst;
      @(negedge clk);
      check64({req, "/R8 valid_out"}, 64'(valid_out), 64'(v));
      check64({req, "/R6/R7 wr_en"}, 64'(wr_en), 64'(v && op != 2'b11 && dst != 5'd0));
      if (v) begin
         check64({req, "/R8 wr_idx"}, 64'(wr_idx), 64'(dst));
         if (op != 2'b11) check64(req, result, model(op, a_rs, b_rt, pos));
      end
      valid_in = 1'b0;
   endtask

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R7";
      endcase
   endfunction

   initial begin
      logic [63:0] a;
      logic [63:0] b;
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(negedge clk);
      check64("R9 reset valid_out", 64'(valid_out), 64'd0);
      check64("R9 reset wr_en", 64'(wr_en), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R9 post-reset result", result, 64'd0);
      check64("R9 post-reset wr_idx", 64'(wr_idx), 64'd0);

      a = 64'hFFFF_FFFF_AABB_CCDD;
      b = 64'hFFFF_FFFF_1122_3344;
      for (int p = 0; p < 4; p++)
         run_op(1'b1, 2'b00, a, b, 5'(p), 5'd3, "R1 byte align");
      run_op(1'b1, 2'b00, 64'h0, 64'h0000_0000_8000_0001, 5'd0, 5'd4, "R4 n=0 sign R1");
      run_op(1'b1, 2'b00, a, b, 5'b11101, 5'd5, "R10 align high bits ignored");
      run_op(1'b1, 2'b00, 64'h1234_5678_0000_00F0, 64'hDEAD_BEEF_0000_0001, 5'd3, 5'd6,
             "R5 upper halves ignored");

      a = 64'h0123_4567_89AB_CDEF;
      b = 64'hFEDC_BA98_7654_3210;
      for (int p = 0; p < 8; p++)
         run_op(1'b1, 2'b01, a, b, 5'(p), 5'd7, "R2 dword align");
      run_op(1'b1, 2'b01, a, b, 5'b11000, 5'd8, "R4 n=0 R10 dword high bits");
      run_op(1'b1, 2'b01, 64'h8000_0000_0000_0000, 64'h0, 5'd7, 5'd9, "R2 no sign ext");

      run_op(1'b1, 2'b10, 64'hFFFF_FFFF_8765_4321, 64'h0000_0000_1111_1111, 5'd0, 5'd10,
             "R3 R4 extract shift 0 gives rs");
      run_op(1'b1, 2'b10, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000, 5'd1, 5'd11,
             "R3 extract shift 1");
      run_op(1'b1, 2'b10, 64'h0000_0000_F000_0000, 64'h0000_0000_0000_0001, 5'd31, 5'd12,
             "R3 extract shift 31");

      run_op(1'b1, 2'b00, a, b, 5'd1, 5'd0, "R6 zero dst");
      run_op(1'b1, 2'b11, a, b, 5'd2, 5'd13, "R7 reserved");
      run_op(1'b0, 2'b00, a, b, 5'd2, 5'd14, "R8 idle");
      run_op(1'b1, 2'b10, a, b, 5'd9, 5'd15, "R8 back-to-back");

      for (int k = 0; k < 600; k++) begin
         logic        v;
         logic [1:0]  op;
         logic [4:0]  dst;
         v   = ($urandom_range(0, 9) != 0);
         op  = 2'($urandom_range(0, 3));
         dst = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom);
         if ($urandom_range(0, 3) == 0) begin
            a = {32'hFFFF_FFFF, $urandom};
            b = {$urandom, 32'h8000_0000 | $urandom};
         end else begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
         end
         run_op(v, op, a, b, 5'($urandom), dst, op_req(op));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule